// File: doc/BRIEF.md
# Sticky Fault Register with Flag-Pin Serial Readout

This block sits beside the gate-drive logic of a three-phase bridge. It gathers ten fault events into a sticky register: six drain-source overvoltage events (high side and low side of each phase), three bootstrap undervoltage events and a regulator undervoltage condition. It reports a summary of the register and of the live supply, regulator and temperature conditions on two open-drain flag pins. The block only drives pull-low enables for the pins. The pin pads, the analog comparators and the reset pulse-width timer are outside it.

When the summary releases the second flag pin, an external controller may use that pin as a clock. Each falling edge it produces moves one register bit onto the first flag pin. After all ten bits have been shifted, one more falling edge clears the register. Events that arrive while a readout is under way are held back. They enter the register once the readout ends, so the bits being shifted out never change.

Top module: `fault_flag_serializer`

## Requirements
- R1: While `rstN` is low the register, the readout state and any held-back events are cleared, and both pins are pulled low (`flagAPullLow`=1, `flagBPullLow`=1).
- R2: A one-cycle event sets its register bit, and the bit stays set until reset, a completed readout, or supply undervoltage. Register bit k is shifted out k-th. Bits 0..5 are drain-source faults in the order A, B, C high side, then A, B, C low side. Bit 6 is regulator undervoltage. Bits 7..9 are bootstrap undervoltage for phases A, B, C.
- R3: With no readout active, the pins report conditions in this priority order. Any undervoltage (register bits 6..9 or live `regUv`) releases both pins. Otherwise any drain-source bit pulls A low and releases B. Otherwise live `overTemp` releases A and pulls B low. With no fault at all, both pins are pulled low.
- R4: While `supplyUv` is high, both pins are released, the register is held at zero and any readout is abandoned.
- R5: While the block pulls pin B low, controller activity on pin B starts no readout.
- R6: When pin B is released, its first falling edge starts a readout that presents bit 0 on pin A. Each later falling edge presents the next bit. A bit value of 1 releases pin A and a value of 0 pulls it low. Pin B stays released for the whole readout.
- R7: The falling edge after bit 9 clears the register and ends the readout. The pins then show only the conditions still present, so a live `regUv` sets bit 6 again.
- R8: Events that arrive during a readout do not change the bits being shifted out. They are merged into the register when the readout ends.
- R9: A `regUv` level sets bit 6. The bit stays set after `regUv` falls, so the pins keep both released until the bit is read out or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset; also clears the fault register |
| dsPulse | input | 2*NUM_PHASES | Drain-source overvoltage event pulses: A, B, C high side, then A, B, C low side |
| bootPulse | input | NUM_PHASES | Bootstrap undervoltage event pulses, phase A first |
| regUv | input | 1 | Regulator undervoltage level |
| supplyUv | input | 1 | Logic supply undervoltage level |
| overTemp | input | 1 | Overtemperature level |
| flagBIn | input | 1 | Sampled level of flag pin B (the readout clock) |
| flagAPullLow | output | 1 | 1 pulls flag pin A low; 0 releases it |
| flagBPullLow | output | 1 | 1 pulls flag pin B low; 0 releases it |

## Verification
An event or level change at the inputs reaches the pin enables two clock edges later: one edge to update the register, one for the output register. A falling edge on pin B needs four edges: two synchronizer stages, one to update the readout state, and one for the output register. After every stimulus change the bench waits six full cycles before it samples, so each check falls after every result is due. Inputs are driven and outputs sampled on the falling clock edge. The bench models pin B as the AND of the controller's release and the block's enable, so a block that pulls B low hides every controller edge.

// File: rtl/fault_pkg.sv
package fault_pkg;
  // strobes from the readout control to the fault datapath
  typedef struct packed {
    logic start;    // first falling edge: snapshot register into shifter
    logic advance;  // later falling edge: move to next bit
    logic finish;   // edge after last bit: clear and merge held events
    logic active;   // readout in progress
  } rdStrobe_t;
endpackage

// File: rtl/fault_capture.sv
module fault_capture
  import fault_pkg::*;
#(
  parameter int NUM_PHASES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_PHASES-1:0] dsPulse,
  input  logic [NUM_PHASES-1:0]   bootPulse,
  input  logic                    regUv,
  input  logic                    supplyUv,
  input  rdStrobe_t               strb,
  output logic [3*NUM_PHASES:0]   faultReg,
  output logic                    serialBit
);
  localparam int DS_W    = 2 * NUM_PHASES;
  localparam int FAULT_W = DS_W + 1 + NUM_PHASES;

  logic [FAULT_W-1:0] newEvt;
  logic [FAULT_W-1:0] heldEvt;
  logic [FAULT_W-1:0] shiftReg;
  logic               holdOff;

  assign newEvt    = {bootPulse, regUv, dsPulse};
  assign holdOff   = strb.active | strb.start;
  assign serialBit = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultReg <= '0;
      heldEvt  <= '0;
      shiftReg <= '0;
    end else if (supplyUv) begin
      faultReg <= '0;
      heldEvt  <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.finish) begin
        faultReg <= heldEvt | newEvt;
        heldEvt  <= '0;
      end else if (holdOff) begin
        heldEvt  <= heldEvt | newEvt;
      end else begin
        faultReg <= faultReg | newEvt;
      end
      if (strb.start) begin
        shiftReg <= faultReg;
      end else if (strb.advance) begin
        shiftReg <= {1'b0, shiftReg[FAULT_W-1:1]};
      end
    end
  end

  // R2: outside supply undervoltage and readout end, no set bit is lost
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyUv && !strb.finish) |=> ((faultReg & $past(faultReg)) == $past(faultReg)))
    else $error("R2 sticky bit lost");

  // R4: supply undervoltage leaves the register empty
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rstN)
    supplyUv |=> (faultReg == '0))
    else $error("R4 register not cleared");

  // R8: register frozen while a readout runs
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.finish && !supplyUv) |=> $stable(faultReg))
    else $error("R8 register changed during readout");
endmodule

// File: rtl/fault_read_ctrl.sv
module fault_read_ctrl
  import fault_pkg::*;
#(
  parameter int FAULT_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyUv,
  input  logic      readable,
  input  logic      flagBIn,
  output rdStrobe_t strb
);
  localparam int IDX_W = $clog2(FAULT_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FAULT_W - 1);

  logic [SYNC_STAGES-1:0] syncB;
  logic                   prevB;
  logic                   fallB;
  logic                   active;
  logic [IDX_W-1:0]       bitIdx;
  logic                   atLast;

  assign fallB  = prevB & ~syncB[SYNC_STAGES-1];
  assign atLast = (bitIdx == LAST_IDX);

  always_comb begin
    strb         = '0;
    strb.active  = active;
    strb.start   = !supplyUv && !active && readable && fallB;
    strb.advance = !supplyUv && active && fallB && !atLast;
    strb.finish  = !supplyUv && active && fallB && atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncB <= '0;
      prevB <= 1'b0;
    end else begin
      syncB <= {syncB[SYNC_STAGES-2:0], flagBIn};
      prevB <= syncB[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitIdx <= '0;
    end else if (supplyUv) begin
      active <= 1'b0;
      bitIdx <= '0;
    end else if (strb.start) begin
      active <= 1'b1;
      bitIdx <= '0;
    end else if (strb.advance) begin
      bitIdx <= bitIdx + 1'b1;
    end else if (strb.finish) begin
      active <= 1'b0;
      bitIdx <= '0;
    end
  end

  // R5: no readout begins while pin B is held low by the block
  a_r5_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !readable) |=> !active)
    else $error("R5 readout started while not readable");

  // R6: bit position holds between edges
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (active && !fallB && !supplyUv) |=> $stable(bitIdx))
    else $error("R6 bit position moved without an edge");

  // R7: the edge after the last bit ends the readout
  a_r7_done: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !active)
    else $error("R7 readout did not end");
endmodule

// File: rtl/fault_flag_encoder.sv
module fault_flag_encoder #(
  parameter int NUM_PHASES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3*NUM_PHASES:0] faultReg,
  input  logic                  regUv,
  input  logic                  supplyUv,
  input  logic                  overTemp,
  input  logic                  readActive,
  input  logic                  serialBit,
  output logic                  readable,
  output logic                  flagAPullLow,
  output logic                  flagBPullLow
);
  localparam int DS_W    = 2 * NUM_PHASES;
  localparam int FAULT_W = DS_W + 1 + NUM_PHASES;

  logic anyUv;
  logic shortFault;
  logic nextALow;
  logic nextBLow;

  assign anyUv      = regUv | (|faultReg[FAULT_W-1:DS_W]);
  assign shortFault = |faultReg[DS_W-1:0];
  assign readable   = !supplyUv && !readActive && (anyUv || shortFault);

  always_comb begin
    nextALow = 1'b1;
    nextBLow = 1'b1;
    if (supplyUv) begin
      nextALow = 1'b0;
      nextBLow = 1'b0;
    end else if (readActive) begin
      nextALow = !serialBit;
      nextBLow = 1'b0;
    end else if (anyUv) begin
      nextALow = 1'b0;
      nextBLow = 1'b0;
    end else if (shortFault) begin
      nextBLow = 1'b0;
    end else if (overTemp) begin
      nextALow = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagAPullLow <= 1'b1;
      flagBPullLow <= 1'b1;
    end else begin
      flagAPullLow <= nextALow;
      flagBPullLow <= nextBLow;
    end
  end

  // R4: supply undervoltage releases both pins
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    supplyUv |=> (!flagAPullLow && !flagBPullLow))
    else $error("R4 pins not released");

  // R3: no fault of any kind keeps both pins low
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyUv && !readActive && !regUv && !overTemp && faultReg == '0)
      |=> (flagAPullLow && flagBPullLow))
    else $error("R3 idle pins not low");

  // R6: pin B stays released through a readout
  a_r6_b_released: assert property (@(posedge clk) disable iff (!rstN)
    (readActive && !supplyUv) |=> !flagBPullLow)
    else $error("R6 pin B pulled during readout");
endmodule

// File: rtl/fault_flag_serializer.sv
module fault_flag_serializer
  import fault_pkg::*;
#(
  parameter int NUM_PHASES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_PHASES-1:0] dsPulse,
  input  logic [NUM_PHASES-1:0]   bootPulse,
  input  logic                    regUv,
  input  logic                    supplyUv,
  input  logic                    overTemp,
  input  logic                    flagBIn,
  output logic                    flagAPullLow,
  output logic                    flagBPullLow
);
  localparam int FAULT_W = 3 * NUM_PHASES + 1;

  rdStrobe_t          strb;
  logic [FAULT_W-1:0] faultReg;
  logic               serialBit;
  logic               readable;

  fault_capture #(.NUM_PHASES(NUM_PHASES)) uCapture (
    .clk       (clk),
    .rstN      (rstN),
    .dsPulse   (dsPulse),
    .bootPulse (bootPulse),
    .regUv     (regUv),
    .supplyUv  (supplyUv),
    .strb      (strb),
    .faultReg  (faultReg),
    .serialBit (serialBit)
  );

  fault_read_ctrl #(.FAULT_W(FAULT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyUv (supplyUv),
    .readable (readable),
    .flagBIn  (flagBIn),
    .strb     (strb)
  );

  fault_flag_encoder #(.NUM_PHASES(NUM_PHASES)) uEncoder (
    .clk          (clk),
    .rstN         (rstN),
    .faultReg     (faultReg),
    .regUv        (regUv),
    .supplyUv     (supplyUv),
    .overTemp     (overTemp),
    .readActive   (strb.active),
    .serialBit    (serialBit),
    .readable     (readable),
    .flagAPullLow (flagAPullLow),
    .flagBPullLow (flagBPullLow)
  );
endmodule

// File: tb/fault_flag_serializer_test.sv
`timescale 1ns/1ps
module fault_flag_serializer_test;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] dsPulse = '0;
  logic [2:0] bootPulse = '0;
  logic       regUvPulse = 1'b0;
  logic       regUvLevel = 1'b0;
  logic       supplyUv = 1'b0;
  logic       overTemp = 1'b0;
  logic       ctrlB = 1'b1;
  logic       regUv;
  logic       flagBIn;
  logic       flagAPullLow;
  logic       flagBPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] expReg = '0;
  logic [9:0] expHeld = '0;
  bit         reading = 0;

  always #2.5 clk = ~clk;

  assign regUv   = regUvPulse | regUvLevel;
  assign flagBIn = ctrlB & ~flagBPullLow;

  fault_flag_serializer uut (
    .clk(clk), .rstN(rstN), .dsPulse(dsPulse), .bootPulse(bootPulse),
    .regUv(regUv), .supplyUv(supplyUv), .overTemp(overTemp),
    .flagBIn(flagBIn), .flagAPullLow(flagAPullLow), .flagBPullLow(flagBPullLow)
  );

  // expected {aLow, bLow} outside a readout
  function automatic logic [1:0] expPins(input logic [9:0] r, input logic uv,
                                         input logic ot, input logic suv);
    if (suv) return 2'b00;
    if ((|r[9:6]) || uv) return 2'b00;
    if (|r[5:0]) return 2'b10;
    if (ot) return 2'b01;
    return 2'b11;
  endfunction

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic checkPins(input string req);
    logic [1:0] e;
    e = expPins(expReg, regUvLevel, overTemp, supplyUv);
    checkVal(req, {8'd0, flagAPullLow, flagBPullLow}, {8'd0, e});
  endtask

  task automatic inject(input logic [9:0] b);
    dsPulse    = b[5:0];
    regUvPulse = b[6];
    bootPulse  = b[9:7];
    if (reading) expHeld = expHeld | b;
    else expReg = expReg | b;
    @(negedge clk);
    dsPulse    = '0;
    regUvPulse = 1'b0;
    bootPulse  = '0;
  endtask

  task automatic setRegUv(input logic v);
    regUvLevel = v;
    if (v) begin
      if (reading) expHeld[6] = 1'b1;
      else expReg[6] = 1'b1;
    end
  endtask

  // full readout; optional injection before bit injAt
  task automatic readAll(output logic [9:0] got, input int injAt, input logic [9:0] injBits);
    got = '0;
    reading = 1;
    expHeld = regUvLevel ? 10'h040 : 10'h000;
    ctrlB = 1'b0;
    waitCycles(SETTLE);
    got[0] = !flagAPullLow;
    for (int k = 1; k < 10; k++) begin
      if (k == injAt) inject(injBits);
      ctrlB = 1'b1;
      waitCycles(SETTLE);
      ctrlB = 1'b0;
      waitCycles(SETTLE);
      got[k] = !flagAPullLow;
    end
    ctrlB = 1'b1;
    waitCycles(SETTLE);
    ctrlB = 1'b0;
    waitCycles(SETTLE);
    reading = 0;
    expReg = expHeld | (regUvLevel ? 10'h040 : 10'h000);
    expHeld = '0;
    ctrlB = 1'b1;
    waitCycles(SETTLE);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] got;
    logic [9:0] snap;
    void'($urandom(32'd7177));

    waitCycles(3);
    checkPins("R1 reset state");
    rstN = 1'b1;
    waitCycles(SETTLE);
    checkPins("R1 idle after reset");

    // R3 / R5: overtemperature alone, controller clocks have no effect
    overTemp = 1'b1;
    waitCycles(SETTLE);
    checkPins("R3 overtemp alone");
    for (int k = 0; k < 3; k++) begin
      ctrlB = 1'b0; waitCycles(SETTLE);
      ctrlB = 1'b1; waitCycles(SETTLE);
    end
    checkPins("R5 overtemp edges ignored");
    inject(10'b00_0000_0100);  // C high side
    waitCycles(SETTLE);
    checkPins("R3 short with overtemp");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R5 readout starts at bit 0", got, snap);
    checkPins("R7 overtemp shows after clear");
    overTemp = 1'b0;
    waitCycles(SETTLE);
    checkPins("R7 idle after overtemp drop");

    // R2 / R6: single low-side short, held across many cycles
    inject(10'b00_0000_1000);
    waitCycles(40);
    checkPins("R2 short sticky");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R6 order low-side A", got, snap);
    checkPins("R7 cleared after read");

    // R3: bootstrap undervoltage releases both
    inject(10'b10_0000_0000);
    waitCycles(SETTLE);
    checkPins("R3 bootstrap undervoltage");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R6 order bootstrap C last", got, snap);
    checkPins("R7 cleared after bootstrap read");

    // R9: regulator undervoltage latched after the level drops
    setRegUv(1'b1);
    waitCycles(SETTLE);
    checkPins("R9 regulator uv live");
    setRegUv(1'b0);
    waitCycles(SETTLE);
    checkPins("R9 regulator uv latched");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R9 bit 6 read", got, snap);
    checkPins("R7 cleared after uv read");

    // R7: live regulator uv at end of readout sets bit 6 again
    inject(10'b00_0000_0001);
    setRegUv(1'b1);
    waitCycles(SETTLE);
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R7 read with live uv", got, snap);
    setRegUv(1'b0);
    waitCycles(SETTLE);
    checkPins("R7 uv bit relatched");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R7 relatched bit 6", got, snap);

    // R8: event during readout is deferred
    inject(10'b01_0010_0000);
    waitCycles(SETTLE);
    snap = expReg;
    readAll(got, 4, 10'b00_0000_0100);
    checkVal("R8 read unaffected", got, snap);
    checkPins("R8 deferred event shows");
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R8 deferred event read", got, snap);

    // R4: supply undervoltage
    inject(10'b00_1000_0011);
    waitCycles(SETTLE);
    supplyUv = 1'b1;
    expReg = '0;
    waitCycles(SETTLE);
    checkPins("R4 both released");
    supplyUv = 1'b0;
    waitCycles(SETTLE);
    checkPins("R4 register cleared");

    // R4: supply undervoltage in mid readout abandons it
    inject(10'b00_0001_0000);
    waitCycles(SETTLE);
    ctrlB = 1'b0; waitCycles(SETTLE);
    ctrlB = 1'b1; waitCycles(SETTLE);
    ctrlB = 1'b0; waitCycles(SETTLE);
    supplyUv = 1'b1;
    expReg = '0;
    waitCycles(SETTLE);
    checkPins("R4 released during readout");
    ctrlB = 1'b1;
    waitCycles(SETTLE);
    supplyUv = 1'b0;
    waitCycles(SETTLE);
    checkPins("R4 readout abandoned");
    inject(10'b00_0000_0010);
    waitCycles(SETTLE);
    snap = expReg;
    readAll(got, -1, '0);
    checkVal("R4 fresh readout from bit 0", got, snap);

    // R1: reset clears register
    inject(10'b01_0100_0000);
    waitCycles(SETTLE);
    rstN = 1'b0;
    expReg = '0;
    waitCycles(2);
    checkPins("R1 reset pins");
    rstN = 1'b1;
    waitCycles(SETTLE);
    checkPins("R1 register cleared by reset");

    // random mixes
    for (int it = 0; it < 30; it++) begin
      logic [9:0] b;
      b = 10'($urandom) & 10'($urandom) & 10'($urandom);
      overTemp = 1'($urandom);
      inject(b);
      if (($urandom % 2) == 1) inject(10'($urandom) & 10'($urandom) & 10'($urandom));
      waitCycles(SETTLE);
      checkPins("R3 random summary");
      if (expReg != '0) begin
        snap = expReg;
        if (($urandom % 3) == 0)
          readAll(got, 1 + int'($urandom % 9), 10'($urandom) & 10'($urandom));
        else
          readAll(got, -1, '0);
        checkVal("R6 random readout", got, snap);
        checkPins("R7 random after clear");
        if (expReg != '0) begin
          snap = expReg;
          readAll(got, -1, '0);
          checkVal("R8 random deferred read", got, snap);
        end
      end
      overTemp = 1'b0;
      waitCycles(SETTLE);
      checkPins("R2 random settle");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule